// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Unit

This block decides, for a small 8-bit processor core, when an interrupt is taken and which one. Five peripheral sources feed it: vertical blank, display status, timer, serial link and keypad. Each sends single-cycle request pulses that are held in a pending register. An enable mask and a master enable flag together decide which pending sources may interrupt. Software can also overwrite the pending register directly.

The core raises `boundary_i` in the cycle it finishes an instruction. In that cycle it also says whether the instruction was an enable, disable or return-from-interrupt operation. The unit first applies these control effects, including an enable that was queued one instruction earlier. It then checks the interrupts at that same boundary. When it takes one, it presents a registered one-cycle strobe with the handler address and the stall length, clears the master enable and acknowledges only the chosen source. For the length of the stall it then ignores further boundaries, while the core pushes the return address (the next instruction's address) and fetches the handler.

Top module: `irq_dispatch_unit`

## Requirements
- R1: An interrupt is taken at an accepted boundary only when two conditions hold: the master enable, after that boundary's control effects, is set, and the bitwise AND of mask and pending over bits 4:0 is non-zero. A mask write stores bits 4:0 of `mask_wdata_i`.
- R2: When several sources qualify, the lowest bit index wins. Bit 0 is vertical blank, bit 1 display status, bit 2 timer, bit 3 serial, bit 4 keypad.
- R3: The handler address is 0x40 + 8 × index of the chosen source, so the addresses are 0x40, 0x48, 0x50, 0x58 and 0x60. It appears on `vector_o` together with `dispatch_o` one clock after the boundary. Both outputs are zero otherwise.
- R4: Taking an interrupt clears the master enable and only the chosen source's pending bit. The other pending bits are left unchanged.
- R5: Request pulses OR into the pending register. A pending write replaces the register's contents. A pulse in the same cycle as a write or an acknowledge still leaves its bit set.
- R6: `stall_len_o` reads 20 with the strobe and 0 otherwise. `busy_o` is high for 20 cycles starting with the strobe. A boundary seen while `busy_o` is high changes no state.
- R7: A disable operation clears the master enable at its own boundary. A return-from-interrupt sets it at its own boundary. If both are flagged, the return wins.
- R8: An enable operation leaves the flag unchanged at its own boundary. It sets the flag at the next accepted boundary, which overrides a disable flagged there, and an interrupt may be taken at that same boundary.
- R9: Bits 7:5 of the pending and mask write data are ignored. A pending write of only those bits leaves the pending register empty, and no dispatch follows.
- R10: After synchronous reset, the pending register, the mask, the master enable, the queued enable, the strobe, the vector, the stall length and busy are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Request pulses, one per source |
| pend_wr_i | input | 1 | Write strobe for the pending register |
| pend_wdata_i | input | 8 | Pending write data |
| mask_wr_i | input | 1 | Write strobe for the enable mask |
| mask_wdata_i | input | 8 | Mask write data |
| boundary_i | input | 1 | Core finished an instruction this cycle |
| op_ei_i | input | 1 | Finishing instruction is an enable |
| op_di_i | input | 1 | Finishing instruction is a disable |
| op_reti_i | input | 1 | Finishing instruction is a return-from-interrupt |
| dispatch_o | output | 1 | One-cycle interrupt taken strobe |
| vector_o | output | 16 | Handler address, valid with the strobe |
| stall_len_o | output | 5 | Stall cycles, valid with the strobe |
| busy_o | output | 1 | Stall window in progress |
| ime_o | output | 1 | Master enable flag |
| pend_o | output | 5 | Pending register |
| mask_o | output | 5 | Enable mask |

## Verification
The assertions check the following on every cycle:
- Each strobe comes with an aligned handler address inside the valid range, the full stall length, a cleared master enable and `busy_o` raised.
- Busy was low before each strobe.
- A non-zero candidate set existed before each strobe.
- Every request pulse is pending one cycle later.
- The priority index agrees with the one-hot grant.
- The queued enable and the disable reach the master flag as required.

Only the bench's scenarios can show the rest:
- The priority order across several sources pending at once.
- The one-instruction delay of an enable and its override of a following disable.
- The exact 20-cycle length of the ignored window.
- The case where a pulse and an acknowledge hit the same bit in the same cycle.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int NSRC      = 5;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 16;
  localparam int VEC_BASE  = 64;
  localparam int VEC_STEP  = 8;
  localparam int STALL_CYC = 20;
endpackage

// File: rtl/irqd_pend_reg.sv
module irqd_pend_reg #(
  parameter int NSRC = irqd_pkg::NSRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic            wr_en_i,
  input  logic [NSRC-1:0] wr_data_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] base;

  always_comb begin
    base = wr_en_i ? wr_data_i : pend_o;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= (base & ~clr_i) | req_i;
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    // R5
    pulse_lands_chk: assert property (@(posedge clk) disable iff (rst)
      req_i[k] |=> pend_o[k]);
  end
endmodule

// File: rtl/irqd_prio_pick.sv
module irqd_prio_pick #(
  parameter int NSRC  = irqd_pkg::NSRC,
  parameter int IDX_W = 3
) (
  input  logic [NSRC-1:0]  cand_i,
  output logic [NSRC-1:0]  grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  localparam int PAD_W = 1 << IDX_W;

  logic [NSRC:0]    seen;
  logic [PAD_W-1:0] grant_pad;

  assign seen[0] = 1'b0;
  for (genvar k = 0; k < NSRC; k++) begin : g_lane
    assign grant_o[k]  = cand_i[k] & ~seen[k];
    assign seen[k+1]   = seen[k] | cand_i[k];
  end
  assign any_o = seen[NSRC];

  always_comb begin
    idx_o = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (cand_i[k]) idx_o = IDX_W'(k);
    end
  end

  always_comb begin
    grant_pad = '0;
    grant_pad[NSRC-1:0] = grant_o;
  end

  // R2
  always_comb begin
    idx_grant_agree_chk: assert (!any_o || grant_pad[idx_o]);
  end
endmodule

// File: rtl/irqd_enable_ctl.sv
module irqd_enable_ctl (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  input  logic ei_i,
  input  logic di_i,
  input  logic reti_i,
  input  logic take_i,
  output logic ime_o,
  output logic ime_eff_o
);
  logic ei_q;

  always_comb begin
    ime_eff_o = ime_o;
    if (di_i)   ime_eff_o = 1'b0;
    if (reti_i) ime_eff_o = 1'b1;
    if (ei_q)   ime_eff_o = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ime_o <= 1'b0;
      ei_q  <= 1'b0;
    end else if (step_i) begin
      ime_o <= take_i ? 1'b0 : ime_eff_o;
      ei_q  <= ei_q ? 1'b0 : ei_i;
    end
  end

  // R8
  queued_enable_chk: assert property (@(posedge clk) disable iff (rst)
    step_i && ei_q && !take_i |=> ime_o);
  // R7
  disable_now_chk: assert property (@(posedge clk) disable iff (rst)
    step_i && di_i && !reti_i && !ei_q |=> !ime_o);
endmodule

// File: rtl/irq_dispatch_unit.sv
module irq_dispatch_unit #(
  parameter int NSRC      = irqd_pkg::NSRC,
  parameter int DATA_W    = irqd_pkg::DATA_W,
  parameter int ADDR_W    = irqd_pkg::ADDR_W,
  parameter int VEC_BASE  = irqd_pkg::VEC_BASE,
  parameter int VEC_STEP  = irqd_pkg::VEC_STEP,
  parameter int STALL_CYC = irqd_pkg::STALL_CYC,
  localparam int IDX_W    = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CNT_W    = $clog2(STALL_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   req_i,
  input  logic              pend_wr_i,
  input  logic [DATA_W-1:0] pend_wdata_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  input  logic              boundary_i,
  input  logic              op_ei_i,
  input  logic              op_di_i,
  input  logic              op_reti_i,
  output logic              dispatch_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic [CNT_W-1:0]  stall_len_o,
  output logic              busy_o,
  output logic              ime_o,
  output logic [NSRC-1:0]   pend_o,
  output logic [NSRC-1:0]   mask_o
);
  localparam int VEC_LAST = VEC_BASE + VEC_STEP * (NSRC - 1);

  logic [CNT_W-1:0]  stall_cnt;
  logic              step, ime_eff, any, take;
  logic [NSRC-1:0]   cand, grant, clr;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] vec_calc;
  logic              unused_hi;

  assign unused_hi = ^{pend_wdata_i[DATA_W-1:NSRC], mask_wdata_i[DATA_W-1:NSRC]};

  assign busy_o = (stall_cnt != '0);
  assign step   = boundary_i & ~busy_o;
  assign cand   = mask_o & pend_o;
  assign take   = step & ime_eff & any;
  assign clr    = take ? grant : '0;
  assign vec_calc = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(idx);

  irqd_pend_reg #(.NSRC(NSRC)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .wr_en_i   (pend_wr_i),
    .wr_data_i (pend_wdata_i[NSRC-1:0]),
    .clr_i     (clr),
    .pend_o    (pend_o)
  );

  irqd_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .cand_i  (cand),
    .grant_o (grant),
    .idx_o   (idx),
    .any_o   (any)
  );

  irqd_enable_ctl u_en (
    .clk       (clk),
    .rst       (rst),
    .step_i    (step),
    .ei_i      (op_ei_i),
    .di_i      (op_di_i),
    .reti_i    (op_reti_i),
    .take_i    (take),
    .ime_o     (ime_o),
    .ime_eff_o (ime_eff)
  );

  always_ff @(posedge clk) begin
    if (rst) mask_o <= '0;
    else if (mask_wr_i) mask_o <= mask_wdata_i[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dispatch_o  <= 1'b0;
      vector_o    <= '0;
      stall_len_o <= '0;
      stall_cnt   <= '0;
    end else begin
      dispatch_o  <= take;
      vector_o    <= take ? vec_calc : '0;
      stall_len_o <= take ? CNT_W'(STALL_CYC) : '0;
      if (take)                stall_cnt <= CNT_W'(STALL_CYC);
      else if (stall_cnt != 0) stall_cnt <= stall_cnt - CNT_W'(1);
    end
  end

  // R3
  vector_shape_chk: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> (vector_o >= ADDR_W'(VEC_BASE)) && (vector_o <= ADDR_W'(VEC_LAST))
                   && (vector_o % ADDR_W'(VEC_STEP) == '0));
  // R4
  ime_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> !ime_o);
  // R6
  stall_start_chk: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> busy_o && (stall_len_o == CNT_W'(STALL_CYC)));
  // R6
  no_take_in_stall_chk: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> !$past(busy_o));
  // R1
  had_candidate_chk: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> ($past(cand) != '0));
endmodule

// File: tb/tb_irq_dispatch_unit.sv
module tb_irq_dispatch_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] b_req = '0;
  logic b_pwr = 1'b0, b_mwr = 1'b0;
  logic [7:0] b_pdata = '0, b_mdata = '0;
  logic b_bnd = 1'b0, b_ei = 1'b0, b_di = 1'b0, b_reti = 1'b0;

  logic        dispatch_o, busy_o, ime_o;
  logic [15:0] vector_o;
  logic [4:0]  stall_len_o, pend_o, mask_o;

  int checks = 0, errors = 0;
  int m_pend, m_mask, m_ime, m_eiq, m_cnt, m_disp, m_vec, m_stl;

  always #10 clk = ~clk;

  irq_dispatch_unit dut (
    .clk(clk), .rst(rst), .req_i(b_req),
    .pend_wr_i(b_pwr), .pend_wdata_i(b_pdata),
    .mask_wr_i(b_mwr), .mask_wdata_i(b_mdata),
    .boundary_i(b_bnd), .op_ei_i(b_ei), .op_di_i(b_di), .op_reti_i(b_reti),
    .dispatch_o(dispatch_o), .vector_o(vector_o), .stall_len_o(stall_len_o),
    .busy_o(busy_o), .ime_o(ime_o), .pend_o(pend_o), .mask_o(mask_o)
  );

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int ie, sel, p;
    if (rst) begin
      m_pend = 0; m_mask = 0; m_ime = 0; m_eiq = 0;
      m_cnt = 0; m_disp = 0; m_vec = 0; m_stl = 0;
      return;
    end
    sel = -1;
    ie  = m_ime;
    if (b_bnd && m_cnt == 0) begin
      if (b_di)   ie = 0;
      if (b_reti) ie = 1;
      if (m_eiq)  ie = 1;
      if (ie == 1)
        for (int k = 0; k < 5; k++)
          if (sel < 0 && m_mask[k] && m_pend[k]) sel = k;
    end
    p = b_pwr ? (b_pdata & 'h1f) : m_pend;
    if (sel >= 0) p = p & ~(1 << sel);
    m_pend = p | b_req;
    if (b_mwr) m_mask = b_mdata & 'h1f;
    if (b_bnd && m_cnt == 0) begin
      m_ime = (sel >= 0) ? 0 : ie;
      m_eiq = m_eiq ? 0 : b_ei;
    end
    if (sel >= 0) m_cnt = 20;
    else if (m_cnt > 0) m_cnt--;
    m_disp = (sel >= 0);
    m_vec  = (sel >= 0) ? 64 + 8 * sel : 0;
    m_stl  = (sel >= 0) ? 20 : 0;
  endtask

  task automatic compare();
    chk(pend_o, m_pend, "R5 pending");
    chk(mask_o, m_mask, "R1 mask");
    chk(ime_o, m_ime, "R7 master enable");
    chk(dispatch_o, m_disp, "R1 strobe");
    chk(vector_o, m_vec, "R3 vector");
    chk(stall_len_o, m_stl, "R6 stall length");
    chk(busy_o, m_cnt != 0, "R6 busy");
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    b_req = '0; b_pwr = 0; b_mwr = 0; b_bnd = 0; b_ei = 0; b_di = 0; b_reti = 0;
  endtask

  task automatic bnd(logic ei, logic di, logic reti);
    b_bnd = 1; b_ei = ei; b_di = di; b_reti = reti; cyc();
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 40 && busy_o; n++) cyc();
  endtask

  initial begin
    int n;
    cyc(); cyc();
    rst = 0;
    cyc();
    // R10 reset state
    chk({dispatch_o, busy_o, ime_o, pend_o, mask_o, stall_len_o}, 0, "R10 reset");
    chk(vector_o, 0, "R10 vector");

    b_mwr = 1; b_mdata = 8'hff; cyc();
    chk(mask_o, 5'h1f, "R9 mask upper bits");
    b_req = 5'b00100; cyc();
    bnd(0, 0, 0);
    chk(dispatch_o, 0, "R1 disabled no take");
    bnd(1, 0, 0);
    chk(ime_o, 0, "R8 not yet enabled");
    chk(dispatch_o, 0, "R8 no take at EI");
    bnd(0, 0, 0);
    chk(dispatch_o, 1, "R8 take after next instr");
    chk(vector_o, 16'h50, "R3 timer vector");
    chk(pend_o, 0, "R4 timer acked");
    chk(stall_len_o, 20, "R6 stall length");
    bnd(0, 0, 1);
    chk(ime_o, 0, "R6 boundary ignored in stall");
    n = 0;
    while (busy_o && n < 40) begin cyc(); n++; end
    chk(n, 19, "R6 stall window length");

    b_req = 5'b11001; cyc();
    bnd(0, 0, 1);
    chk(vector_o, 16'h40, "R2 vblank first");
    chk(pend_o, 5'b11000, "R4 only chosen bit cleared");
    wait_idle();
    bnd(0, 0, 1);
    chk(vector_o, 16'h58, "R2 serial before keypad");
    wait_idle();
    bnd(0, 0, 1);
    chk(vector_o, 16'h60, "R2 keypad last");
    wait_idle();

    b_mwr = 1; b_mdata = 8'h0e; cyc();
    b_req = 5'b00011; cyc();
    bnd(0, 0, 1);
    chk(vector_o, 16'h48, "R1 masked vblank skipped");
    chk(pend_o, 5'b00001, "R1 masked bit kept");
    wait_idle();

    b_mwr = 1; b_mdata = 8'h00; cyc();
    bnd(0, 0, 1);
    chk(ime_o, 1, "R7 return sets enable");
    bnd(0, 1, 0);
    chk(ime_o, 0, "R7 disable clears");
    bnd(0, 1, 1);
    chk(ime_o, 1, "R7 return wins over disable");
    bnd(0, 1, 0);
    bnd(1, 0, 0);
    bnd(0, 1, 0);
    chk(ime_o, 1, "R8 queued enable overrides disable");

    b_pwr = 1; b_pdata = 8'he0; cyc();
    chk(pend_o, 0, "R9 upper pending bits ignored");
    b_mwr = 1; b_mdata = 8'h1f; cyc();
    bnd(0, 0, 0);
    chk(dispatch_o, 0, "R9 no vector from upper bits");
    b_pwr = 1; b_pdata = 8'h03; b_req = 5'b10000; cyc();
    chk(pend_o, 5'h13, "R5 pulse wins over write");
    b_pwr = 1; b_pdata = 8'h00; b_req = 5'b00010; cyc();
    chk(pend_o, 5'h02, "R5 write replaces plus pulse");
    b_req = 5'b00010; bnd(0, 0, 0);
    chk(vector_o, 16'h48, "R3 status vector");
    chk(pend_o, 5'h02, "R5 pulse survives ack");
    wait_idle();
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule